// File: doc/BRIEF.md
# Sleep State Entry Controller

This controller decides when the system leaves the working state for one of four sleep depths (S1, S3, S4, S5) and drives the control outputs that go with that depth. There are two ways to request sleep. Software can pulse a sleep-enable strobe together with a 2-bit sleep-depth code. A power-button press with no software request selects the deepest state, S5.

While a sleep request is pending or the system is asleep, the controller holds back grants for clock throttling and for low-power C-state entry. It also forces thermal throttling off. Once latched, a sleep state stays in place until a wake input returns the controller to the working state and releases every output.

The outputs are cumulative by depth. Stop-clock is active in every sleep state. CPU-sleep is set by a configuration bit in S1 and is always active in deeper states. The three active-low plane signals are asserted in order of depth. No request value of any kind reaches a state beyond S5.

Top module: `sleep_entry_ctrl`

## Requirements
- R1: A cycle with `sw_sleep_set` high while working, and no sleep entry taking place that cycle, sets `sleep_en_flag` at the next edge and captures `sleep_type` (00=S1, 01=S3, 10=S4, 11=S5). At the following edge the controller enters that state, and `sleep_en_flag` clears by itself.
- R2: A `pwr_button` press while working marks a button request. At the next edge the controller enters S5, unless a software request is also pending; in that case the captured software depth is used.
- R3: The edge after a cycle in which the controller is working, with no request pending and none arriving, `throttle_grant` and `cstate_grant` equal `throttle_req` and `cstate_req`. In every other case both are 0.
- R4: `therm_throttle_dis` is high whenever `sleep_en_flag` is high or a sleep state is held, and low otherwise.
- R5: `stop_clk` is high in S1, S3, S4 and S5 and low when working.
- R6: In S1, `cpu_sleep` follows `cpu_sleep_s1_en` with one cycle of delay. In S3, S4 and S5 it is high. When working it is low.
- R7: Active-low planes: `plane_s3_n` is low in S3/S4/S5, `plane_s4_n` is low in S4/S5, and `plane_s5_n` is low only in S5. All three are high in S1 and when working.
- R8: `wake` while in a sleep state returns the controller to working at the next edge and releases all outputs. `wake` while working has no effect. Sleep strobes and button presses that arrive while asleep are ignored.
- R9: While `rst` is high at an edge, the controller goes to working with no pending request. All active-high outputs are 0 and all plane outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_sleep_set | input | 1 | Software sleep-enable strobe |
| sleep_type | input | 2 | Sleep depth code: 00 S1, 01 S3, 10 S4, 11 S5 |
| pwr_button | input | 1 | Power-button press |
| wake | input | 1 | Return to working state |
| throttle_req | input | 1 | Clock-throttle request |
| cstate_req | input | 1 | C-state entry request |
| cpu_sleep_s1_en | input | 1 | Assert CPU-sleep in S1 |
| sleep_en_flag | output | 1 | Software sleep request pending |
| stop_clk | output | 1 | Stop-clock, active high |
| cpu_sleep | output | 1 | CPU-sleep, active high |
| plane_s3_n | output | 1 | S3 plane control, active low |
| plane_s4_n | output | 1 | S4 plane control, active low |
| plane_s5_n | output | 1 | S5 plane control, active low |
| therm_throttle_dis | output | 1 | Thermal throttling forced off |
| throttle_grant | output | 1 | Throttle granted |
| cstate_grant | output | 1 | C-state entry granted |

## Verification
Some properties are checked on every cycle. The plane signals must nest by depth, and any active plane must come with stop-clock and CPU-sleep. Grants never overlap a pending flag or stop-clock, and stop-clock always comes with thermal disable. A pending flag must be followed by sleep at the next edge, and a wake while asleep must release stop-clock at the next edge.

Other behaviour only the bench scenarios can show, because each case is compared against a cycle model. This covers which depth each type code selects, the S5 default on a button press, the precedence of a software depth over the button, the one-cycle tracking of the S1 configuration bit, and that strobes, presses and wakes are ignored in the wrong state.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  localparam int TYPE_W  = 2;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_WORK = 3'd0,
    ST_S1   = 3'd1,
    ST_S3   = 3'd2,
    ST_S4   = 3'd3,
    ST_S5   = 3'd4
  } slp_state_e;

  // software depth code to state; every code lands on a legal sleep state
  function automatic slp_state_e type_to_state(input logic [TYPE_W-1:0] t);
    case (t)
      2'b00:   return ST_S1;
      2'b01:   return ST_S3;
      2'b10:   return ST_S4;
      default: return ST_S5;
    endcase
  endfunction

endpackage

// File: rtl/sleep_req_latch.sv
module sleep_req_latch
  import sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              working,
  input  logic              enter,
  input  logic              sw_set,
  input  logic              btn,
  input  logic [TYPE_W-1:0] type_in,
  output logic              sw_pend,
  output logic              btn_pend,
  output logic [TYPE_W-1:0] type_q,
  output logic              sw_pend_nxt
);

  logic              btn_pend_nxt;
  logic [TYPE_W-1:0] type_nxt;

  always_comb begin
    sw_pend_nxt  = sw_pend;
    btn_pend_nxt = btn_pend;
    type_nxt     = type_q;
    if (enter || !working) begin
      sw_pend_nxt  = 1'b0;
      btn_pend_nxt = 1'b0;
    end else begin
      if (sw_set) begin
        sw_pend_nxt = 1'b1;
        type_nxt    = type_in;
      end
      if (btn) btn_pend_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_pend  <= 1'b0;
      btn_pend <= 1'b0;
      type_q   <= '0;
    end else begin
      sw_pend  <= sw_pend_nxt;
      btn_pend <= btn_pend_nxt;
      type_q   <= type_nxt;
    end
  end

endmodule

// File: rtl/sleep_arbiter.sv
module sleep_arbiter
  import sleep_pkg::*;
(
  input  slp_state_e        state_q,
  input  logic              sw_pend,
  input  logic              btn_pend,
  input  logic [TYPE_W-1:0] type_q,
  input  logic              wake,
  input  logic              sw_set,
  input  logic              btn,
  input  logic              thr_req,
  input  logic              cst_req,
  output logic              working,
  output logic              enter,
  output slp_state_e        state_nxt,
  output logic              thr_gnt_nxt,
  output logic              cst_gnt_nxt
);

  logic quiet;

  always_comb begin
    working   = (state_q == ST_WORK);
    enter     = working && (sw_pend || btn_pend);
    state_nxt = state_q;
    if (!working) begin
      if (wake) state_nxt = ST_WORK;
    end else if (enter) begin
      // software depth outranks the button default
      state_nxt = sw_pend ? type_to_state(type_q) : ST_S5;
    end
    // sleep in any phase excludes throttle and C-state grants
    quiet       = working && !sw_pend && !btn_pend && !sw_set && !btn;
    thr_gnt_nxt = quiet && thr_req;
    cst_gnt_nxt = quiet && cst_req;
  end

endmodule

// File: rtl/sleep_out_enc.sv
module sleep_out_enc
  import sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  slp_state_e state_nxt,
  input  logic       s1_cpu_cfg,
  input  logic       sw_pend_nxt,
  input  logic       thr_gnt_nxt,
  input  logic       cst_gnt_nxt,
  output logic       stop_clk,
  output logic       cpu_sleep,
  output logic       plane_s3_n,
  output logic       plane_s4_n,
  output logic       plane_s5_n,
  output logic       therm_dis,
  output logic       thr_gnt,
  output logic       cst_gnt
);

  logic asleep;
  logic cpu_d, s3_d, s4_d, s5_d;

  always_comb begin
    asleep = (state_nxt != ST_WORK);
    cpu_d  = (state_nxt == ST_S1) ? s1_cpu_cfg : asleep;
    s3_d   = (state_nxt == ST_S3) || (state_nxt == ST_S4) || (state_nxt == ST_S5);
    s4_d   = (state_nxt == ST_S4) || (state_nxt == ST_S5);
    s5_d   = (state_nxt == ST_S5);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_clk   <= 1'b0;
      cpu_sleep  <= 1'b0;
      plane_s3_n <= 1'b1;
      plane_s4_n <= 1'b1;
      plane_s5_n <= 1'b1;
      therm_dis  <= 1'b0;
      thr_gnt    <= 1'b0;
      cst_gnt    <= 1'b0;
    end else begin
      stop_clk   <= asleep;
      cpu_sleep  <= cpu_d;
      plane_s3_n <= ~s3_d;
      plane_s4_n <= ~s4_d;
      plane_s5_n <= ~s5_d;
      therm_dis  <= asleep || sw_pend_nxt;
      thr_gnt    <= thr_gnt_nxt;
      cst_gnt    <= cst_gnt_nxt;
    end
  end

endmodule

// File: rtl/sleep_entry_ctrl.sv
module sleep_entry_ctrl
  import sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_sleep_set,
  input  logic [TYPE_W-1:0] sleep_type,
  input  logic              pwr_button,
  input  logic              wake,
  input  logic              throttle_req,
  input  logic              cstate_req,
  input  logic              cpu_sleep_s1_en,
  output logic              sleep_en_flag,
  output logic              stop_clk,
  output logic              cpu_sleep,
  output logic              plane_s3_n,
  output logic              plane_s4_n,
  output logic              plane_s5_n,
  output logic              therm_throttle_dis,
  output logic              throttle_grant,
  output logic              cstate_grant
);

  slp_state_e        state_q, state_nxt;
  logic              working, enter;
  logic              sw_pend, btn_pend, sw_pend_nxt;
  logic [TYPE_W-1:0] type_q;
  logic              thr_gnt_nxt, cst_gnt_nxt;

  sleep_req_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .working    (working),
    .enter      (enter),
    .sw_set     (sw_sleep_set),
    .btn        (pwr_button),
    .type_in    (sleep_type),
    .sw_pend    (sw_pend),
    .btn_pend   (btn_pend),
    .type_q     (type_q),
    .sw_pend_nxt(sw_pend_nxt)
  );

  sleep_arbiter u_arb (
    .state_q    (state_q),
    .sw_pend    (sw_pend),
    .btn_pend   (btn_pend),
    .type_q     (type_q),
    .wake       (wake),
    .sw_set     (sw_sleep_set),
    .btn        (pwr_button),
    .thr_req    (throttle_req),
    .cst_req    (cstate_req),
    .working    (working),
    .enter      (enter),
    .state_nxt  (state_nxt),
    .thr_gnt_nxt(thr_gnt_nxt),
    .cst_gnt_nxt(cst_gnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_WORK;
    else     state_q <= state_nxt;
  end

  sleep_out_enc u_enc (
    .clk        (clk),
    .rst        (rst),
    .state_nxt  (state_nxt),
    .s1_cpu_cfg (cpu_sleep_s1_en),
    .sw_pend_nxt(sw_pend_nxt),
    .thr_gnt_nxt(thr_gnt_nxt),
    .cst_gnt_nxt(cst_gnt_nxt),
    .stop_clk   (stop_clk),
    .cpu_sleep  (cpu_sleep),
    .plane_s3_n (plane_s3_n),
    .plane_s4_n (plane_s4_n),
    .plane_s5_n (plane_s5_n),
    .therm_dis  (therm_throttle_dis),
    .thr_gnt    (throttle_grant),
    .cst_gnt    (cstate_grant)
  );

  assign sleep_en_flag = sw_pend;

endmodule

// File: rtl/sleep_entry_ctrl_chk.sv
module sleep_entry_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic wake,
  input logic sleep_en_flag,
  input logic stop_clk,
  input logic cpu_sleep,
  input logic plane_s3_n,
  input logic plane_s4_n,
  input logic plane_s5_n,
  input logic therm_throttle_dis,
  input logic throttle_grant,
  input logic cstate_grant
);

  // R1
  flag_enters_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_en_flag |=> (stop_clk && !sleep_en_flag));

  // R3
  grant_exclusion_chk: assert property (@(posedge clk) disable iff (rst)
    (throttle_grant || cstate_grant) |-> (!stop_clk && !sleep_en_flag));

  // R4
  therm_off_in_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_clk || sleep_en_flag) |-> therm_throttle_dis);

  // R6
  cpu_sleep_deep_chk: assert property (@(posedge clk) disable iff (rst)
    !plane_s3_n |-> (cpu_sleep && stop_clk));

  // R7
  plane_s5_nest_chk: assert property (@(posedge clk) disable iff (rst)
    !plane_s5_n |-> !plane_s4_n);

  // R7
  plane_s4_nest_chk: assert property (@(posedge clk) disable iff (rst)
    !plane_s4_n |-> !plane_s3_n);

  // R8
  wake_release_chk: assert property (@(posedge clk) disable iff (rst)
    (wake && stop_clk) |=> (!stop_clk && plane_s3_n && !cpu_sleep));

endmodule

bind sleep_entry_ctrl sleep_entry_ctrl_chk u_chk (
  .clk               (clk),
  .rst               (rst),
  .wake              (wake),
  .sleep_en_flag     (sleep_en_flag),
  .stop_clk          (stop_clk),
  .cpu_sleep         (cpu_sleep),
  .plane_s3_n        (plane_s3_n),
  .plane_s4_n        (plane_s4_n),
  .plane_s5_n        (plane_s5_n),
  .therm_throttle_dis(therm_throttle_dis),
  .throttle_grant    (throttle_grant),
  .cstate_grant      (cstate_grant)
);

// File: tb/sleep_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_entry_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_sleep_set = 1'b0;
  logic [1:0] sleep_type = 2'b00;
  logic       pwr_button = 1'b0;
  logic       wake = 1'b0;
  logic       throttle_req = 1'b0;
  logic       cstate_req = 1'b0;
  logic       cpu_sleep_s1_en = 1'b0;
  logic       sleep_en_flag, stop_clk, cpu_sleep;
  logic       plane_s3_n, plane_s4_n, plane_s5_n;
  logic       therm_throttle_dis, throttle_grant, cstate_grant;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sleep_entry_ctrl dut_i (
    .clk(clk), .rst(rst), .sw_sleep_set(sw_sleep_set), .sleep_type(sleep_type),
    .pwr_button(pwr_button), .wake(wake), .throttle_req(throttle_req),
    .cstate_req(cstate_req), .cpu_sleep_s1_en(cpu_sleep_s1_en),
    .sleep_en_flag(sleep_en_flag), .stop_clk(stop_clk), .cpu_sleep(cpu_sleep),
    .plane_s3_n(plane_s3_n), .plane_s4_n(plane_s4_n), .plane_s5_n(plane_s5_n),
    .therm_throttle_dis(therm_throttle_dis), .throttle_grant(throttle_grant),
    .cstate_grant(cstate_grant)
  );

  // model: depth 0=working, 1=S1, 3=S3, 4=S4, 5=S5
  int   m_depth = 0;
  logic m_sw = 1'b0, m_btn = 1'b0;
  logic [1:0] m_type = 2'b00;
  logic e_thr = 1'b0, e_cst = 1'b0, e_cpu = 1'b0;

  function automatic int depth_of(input logic [1:0] t);
    case (t)
      2'b00:   return 1;
      2'b01:   return 3;
      2'b10:   return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic exp_plane_n(input int d, input int lvl);
    return !(d >= lvl);
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string nm);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(sleep_en_flag, m_sw, "R1", "sleep_en_flag");
    chk(stop_clk, m_depth != 0, "R5", "stop_clk");
    chk(cpu_sleep, e_cpu, "R6", "cpu_sleep");
    chk(plane_s3_n, exp_plane_n(m_depth, 3), "R7", "plane_s3_n");
    chk(plane_s4_n, exp_plane_n(m_depth, 4), "R7", "plane_s4_n");
    chk(plane_s5_n, exp_plane_n(m_depth, 5), "R7", "plane_s5_n");
    chk(therm_throttle_dis, m_sw || (m_depth != 0), "R4", "therm_throttle_dis");
    chk(throttle_grant, e_thr, "R3", "throttle_grant");
    chk(cstate_grant, e_cst, "R3", "cstate_grant");
  endtask

  // drive one cycle, update model at the edge, compare at the falling edge
  task automatic step(input logic s, input logic [1:0] ty, input logic b, input logic w,
                      input logic tr, input logic cr, input logic cf);
    logic working, quiet;
    sw_sleep_set = s; sleep_type = ty; pwr_button = b; wake = w;
    throttle_req = tr; cstate_req = cr; cpu_sleep_s1_en = cf;
    @(posedge clk);
    working = (m_depth == 0);
    quiet   = working && !m_sw && !m_btn && !s && !b;
    e_thr   = quiet && tr;
    e_cst   = quiet && cr;
    if (!working) begin
      if (w) m_depth = 0;
    end else if (m_sw || m_btn) begin
      m_depth = m_sw ? depth_of(m_type) : 5;
      m_sw = 1'b0; m_btn = 1'b0;
    end else begin
      if (s) begin m_sw = 1'b1; m_type = ty; end
      if (b) m_btn = 1'b1;
    end
    e_cpu = (m_depth == 1) ? cf : (m_depth != 0);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset values
    check_all();
    chk(plane_s5_n, 1'b1, "R9", "reset plane_s5_n");
    chk(stop_clk, 1'b0, "R9", "reset stop_clk");
    rst = 1'b0;

    // R3: grants follow requests while idle
    step(0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    // R8: wake while working is ignored
    step(0, 0, 0, 1, 0, 1, 0);
    // R1: each type code, R6 S1 config tracking, R8 wake
    for (int t = 0; t < 4; t++) begin
      step(1, t[1:0], 0, 0, 1, 1, 1);
      step(0, 0, 0, 0, 1, 1, 1);
      step(0, 0, 0, 0, 1, 1, 0);
      step(1, 2'b11, 1, 0, 1, 1, 1);  // R8: ignored while asleep
      step(0, 0, 0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
    end
    // R2: button alone goes to S5
    step(0, 0, 1, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    // R2: button with software request uses software depth
    step(1, 2'b01, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    // R1: strobe during entry cycle is dropped
    step(1, 2'b00, 0, 0, 0, 0, 0);
    step(1, 2'b10, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);

    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 100) < 6, 2'($urandom), ($urandom % 100) < 3,
           ($urandom % 100) < 15, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule